// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block holds eight token latches that two independent ports share to claim a common resource. Each port has its own semaphore select, memory enable, read/write strobe, address and data bus. A port asks for a token by writing 0 to a latch and gives it up, or withdraws an outstanding request, by writing 1. The port then reads the same latch to find out whether it won. A 0 means the port holds the token, and a 1 means it does not.

Each latch records which side owns it, if either does. When the non-owning side asks for the token, the latch queues that request. The queued side takes the token on the same clock edge on which the owner releases it. Each port sees its own view of the latch. When one side holds the token, that side reads 0 and the other side reads 1.

Read results are captured in a per-port output register. A write from the opposite port in the same cycle therefore cannot change a value that is being returned. After a reset every latch is free, and software is still expected to free all latches from both sides as part of its own start-up.

Top module: `sem_latch_bank`

## Requirements
- R1: After reset every latch is free with no queued request, and both `l_dout` and `r_dout` are all ones.
- R2: A write of 0 to a free latch makes the writing side its owner. On the clock edge after a legal read, that side returns all zeros on every data line and the other side returns all ones.
- R3: A write of 0 by the non-owner leaves the owner unchanged and queues the non-owner's request. The owner still reads all zeros and the requester still reads all ones.
- R4: When the owner writes 1 while the other side has a queued request, ownership passes to the other side on that same clock edge and its queued request is cleared.
- R5: When the owner writes 1 with no queued request from the other side, the latch becomes free and both sides read all ones.
- R6: A write of 1 by a side that does not own the latch cancels that side's queued request. A later release by the owner then frees the latch instead of handing it over.
- R7: When both sides write 0 to the same free latch in the same cycle, the left port becomes owner and the right port's request is queued.
- R8: A read accepted in cycle n updates the port's output register at the edge ending cycle n, using the latch state from before any write in that cycle. The output register keeps its value until the port's next accepted read.
- R9: Only address bits [2:0] select a latch and only data bit 0 is sampled on a write. Higher address bits and higher data bits have no effect.
- R10: An access with both `*_sel` and `*_mem_en` high is illegal and is ignored. It does not change any latch and does not update that port's output register.
- R11: Latches are independent: an operation on one latch leaves the ownership and queued requests of every other latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| l_sel | input | 1 | Left semaphore select, active high |
| l_mem_en | input | 1 | Left memory enable; when high together with `l_sel` the access is illegal |
| l_wr | input | 1 | Left direction, 1 = write, 0 = read |
| l_addr | input | ADDR_W (12) | Left address; bits [2:0] pick the latch |
| l_din | input | DATA_W (9) | Left write data; only bit 0 is sampled |
| l_dout | output | DATA_W (9) | Left registered read result, replicated on every bit |
| r_sel | input | 1 | Right semaphore select, active high |
| r_mem_en | input | 1 | Right memory enable; when high together with `r_sel` the access is illegal |
| r_wr | input | 1 | Right direction, 1 = write, 0 = read |
| r_addr | input | ADDR_W (12) | Right address; bits [2:0] pick the latch |
| r_din | input | DATA_W (9) | Right write data; only bit 0 is sampled |
| r_dout | output | DATA_W (9) | Right registered read result, replicated on every bit |

## Verification
Two kinds of collision can land in one cycle: both ports write the same latch together, or one port reads a latch while the other port writes it. The first kind is provoked by driving a 0 from both sides to a free latch in one cycle. It is judged by reading back left ownership, and then by showing that the right side's queued request takes over when the left side releases. The second kind is provoked by having the owner release a latch, handing it to a queued right request, in the very cycle in which the right port reads it. The scoreboard expects the pre-write value in that read and the new ownership in the read that follows.

// File: rtl/sem_pkg.sv
// Shared types and the per-command update rule for the semaphore latch bank.
// Assumes a latch is owned by at most one side and that a side never
// has a queued request on a latch it already owns.
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } sem_owner_e;

    typedef struct packed {
        sem_owner_e owner;
        logic       pend_l;
        logic       pend_r;
    } sem_state_t;

    // Apply one write command from one side to a latch state.
    function automatic sem_state_t sem_apply(sem_state_t s, logic from_right, logic bit_val);
        sem_state_t nx;
        sem_owner_e me;
        sem_owner_e other;
        logic       other_pend;
        nx         = s;
        me         = from_right ? OWN_RIGHT : OWN_LEFT;
        other      = from_right ? OWN_LEFT  : OWN_RIGHT;
        other_pend = from_right ? s.pend_l  : s.pend_r;
        if (!bit_val) begin
            if (s.owner == OWN_NONE) begin
                nx.owner = me;
            end else if (s.owner != me) begin
                if (from_right) nx.pend_r = 1'b1;
                else            nx.pend_l = 1'b1;
            end
        end else begin
            if (s.owner == me) begin
                if (other_pend) begin
                    nx.owner = other;
                    if (from_right) nx.pend_l = 1'b0;
                    else            nx.pend_r = 1'b0;
                end else begin
                    nx.owner = OWN_NONE;
                end
            end else begin
                if (from_right) nx.pend_r = 1'b0;
                else            nx.pend_l = 1'b0;
            end
        end
        return nx;
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
// Per-port command decoder.
// Qualifies the port's strobes into legal read and write pulses and produces
// a one-hot write hit per latch. An access with select and memory enable
// both high is illegal and yields no pulse. Assumes N_SEM == 2**SEL_W.
module sem_port_decode #(
    parameter int N_SEM = 8,
    parameter int SEL_W = 3
) (
    input  logic             sel,
    input  logic             mem_en,
    input  logic             wr,
    input  logic [SEL_W-1:0] addr_lo,
    output logic             wr_go,
    output logic             rd_go,
    output logic [SEL_W-1:0] idx,
    output logic [N_SEM-1:0] wr_hit
);

    logic legal;

    // Legal semaphore access: select active, memory enable inactive.
    assign legal = sel && !mem_en;
    assign wr_go = legal && wr;
    assign rd_go = legal && !wr;
    assign idx   = addr_lo;

    // One-hot write hit, one comparator per latch.
    for (genvar g = 0; g < N_SEM; g++) begin : g_hit
        assign wr_hit[g] = wr_go && (addr_lo == SEL_W'(g));
    end

endmodule

// File: rtl/sem_latch_cell.sv
// One semaphore latch: owner and per-side queued request.
// Same-cycle writes from both sides are applied left first, then right.
// That order gives the left side a tie on a free latch and turns a
// release racing a request into an immediate hand-over.
module sem_latch_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_l,
    input  logic bit_l,
    input  logic wr_r,
    input  logic bit_r,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r
);

    sem_state_t state_q;
    sem_state_t state_d;

    // Next-state: left command, then right command.
    always_comb begin
        state_d = state_q;
        if (wr_l) state_d = sem_apply(state_d, 1'b0, bit_l);
        if (wr_r) state_d = sem_apply(state_d, 1'b1, bit_r);
    end

    // State register, free with no requests after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '{owner: OWN_NONE, pend_l: 1'b0, pend_r: 1'b0};
        else        state_q <= state_d;
    end

    assign own_l  = (state_q.owner == OWN_LEFT);
    assign own_r  = (state_q.owner == OWN_RIGHT);
    assign pend_l = state_q.pend_l;
    assign pend_r = state_q.pend_r;

endmodule

// File: rtl/sem_read_reg.sv
// Per-port read output register.
// On a legal read it captures the port's view of the addressed latch
// (0 = held by this port), replicated across the data width. Otherwise
// it holds its value.
module sem_read_reg #(
    parameter int N_SEM  = 8,
    parameter int SEL_W  = 3,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [SEL_W-1:0]  idx,
    input  logic [N_SEM-1:0]  held,
    output logic [DATA_W-1:0] dout
);

    // Capture the pre-edge latch view on a read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     dout <= '1;
        else if (rd_go) dout <= {DATA_W{~held[idx]}};
    end

endmodule

// File: rtl/sem_latch_bank.sv
// Top of the two-port semaphore latch bank.
// Two port decoders feed N_SEM latch cells. Each port has its own
// registered read path. Address bits above the latch index and data bits
// above bit 0 are ignored by design.
module sem_latch_bank #(
    parameter int N_SEM  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_mem_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_din,
    output logic [DATA_W-1:0] l_dout,
    input  logic              r_sel,
    input  logic              r_mem_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_din,
    output logic [DATA_W-1:0] r_dout
);

    localparam int SEL_W = $clog2(N_SEM);

    logic             wr_go_l, rd_go_l, wr_go_r, rd_go_r;
    logic [SEL_W-1:0] idx_l, idx_r;
    logic [N_SEM-1:0] hit_l, hit_r;
    logic [N_SEM-1:0] own_l, own_r, pend_l, pend_r;
    logic             bit_l, bit_r;
    logic             unused_bits;

    assign bit_l = l_din[0];
    assign bit_r = r_din[0];

    // Ignored upper address and data bits.
    assign unused_bits = ^{l_addr[ADDR_W-1:SEL_W], r_addr[ADDR_W-1:SEL_W],
                           l_din[DATA_W-1:1], r_din[DATA_W-1:1]};

    sem_port_decode #(.N_SEM(N_SEM), .SEL_W(SEL_W)) u_dec_l (
        .sel(l_sel), .mem_en(l_mem_en), .wr(l_wr), .addr_lo(l_addr[SEL_W-1:0]),
        .wr_go(wr_go_l), .rd_go(rd_go_l), .idx(idx_l), .wr_hit(hit_l)
    );

    sem_port_decode #(.N_SEM(N_SEM), .SEL_W(SEL_W)) u_dec_r (
        .sel(r_sel), .mem_en(r_mem_en), .wr(r_wr), .addr_lo(r_addr[SEL_W-1:0]),
        .wr_go(wr_go_r), .rd_go(rd_go_r), .idx(idx_r), .wr_hit(hit_r)
    );

    for (genvar g = 0; g < N_SEM; g++) begin : g_cell
        sem_latch_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .wr_l(hit_l[g]), .bit_l(bit_l),
            .wr_r(hit_r[g]), .bit_r(bit_r),
            .own_l(own_l[g]), .own_r(own_r[g]),
            .pend_l(pend_l[g]), .pend_r(pend_r[g])
        );
    end

    sem_read_reg #(.N_SEM(N_SEM), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go_l), .idx(idx_l),
        .held(own_l), .dout(l_dout)
    );

    sem_read_reg #(.N_SEM(N_SEM), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go_r), .idx(idx_r),
        .held(own_r), .dout(r_dout)
    );

endmodule

// File: rtl/sem_latch_bank_chk.sv
// Assertion checker for sem_latch_bank, attached by bind.
// Relates decoded commands, latch ownership and the registered read outputs.
module sem_latch_bank_chk #(
    parameter int N_SEM  = 8,
    parameter int SEL_W  = 3,
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_sel,
    input logic              l_mem_en,
    input logic              r_sel,
    input logic              r_mem_en,
    input logic [DATA_W-1:0] l_dout,
    input logic [DATA_W-1:0] r_dout,
    input logic              wr_go_l,
    input logic              wr_go_r,
    input logic              rd_go_l,
    input logic              rd_go_r,
    input logic              bit_l,
    input logic              bit_r,
    input logic [SEL_W-1:0]  idx_l,
    input logic [SEL_W-1:0]  idx_r,
    input logic [N_SEM-1:0]  own_l,
    input logic [N_SEM-1:0]  own_r,
    input logic [N_SEM-1:0]  pend_l,
    input logic [N_SEM-1:0]  pend_r
);

    p_read_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go_l |=> (l_dout == {DATA_W{~$past(own_l[idx_l])}}));

    p_nonowner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go_r && !bit_r && own_l[idx_r] && !(wr_go_l && idx_l == idx_r))
        |=> (own_l[$past(idx_r)] && pend_r[$past(idx_r)]));

    p_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go_l && bit_l && own_l[idx_l] && pend_r[idx_l] && !(wr_go_r && idx_r == idx_l))
        |=> own_r[$past(idx_l)]);

    p_handover_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go_r && bit_r && own_r[idx_r] && pend_l[idx_r] && !(wr_go_l && idx_l == idx_r))
        |=> own_l[$past(idx_r)]);

    p_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go_l && bit_l && own_l[idx_l] && !pend_r[idx_l] && !(wr_go_r && idx_r == idx_l))
        |=> (!own_l[$past(idx_l)] && !own_r[$past(idx_l)]));

    p_tie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go_l && wr_go_r && !bit_l && !bit_r && idx_l == idx_r
         && !own_l[idx_l] && !own_r[idx_l])
        |=> (own_l[$past(idx_l)] && pend_r[$past(idx_l)]));

    p_hold_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go_l |=> $stable(l_dout));

    p_hold_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go_r |=> $stable(r_dout));

    p_illegal_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_mem_en) |=> $stable(l_dout));

    p_illegal_right_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sel && r_mem_en) |=> $stable(r_dout));

endmodule

bind sem_latch_bank sem_latch_bank_chk #(
    .N_SEM(N_SEM), .SEL_W(SEL_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .r_sel(r_sel), .r_mem_en(r_mem_en),
    .l_dout(l_dout), .r_dout(r_dout),
    .wr_go_l(wr_go_l), .wr_go_r(wr_go_r), .rd_go_l(rd_go_l), .rd_go_r(rd_go_r),
    .bit_l(bit_l), .bit_r(bit_r), .idx_l(idx_l), .idx_r(idx_r),
    .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/sem_latch_bank_tb.sv
// Scoreboard bench: driver tasks queue the expected read results and a
// monitor pops them when the read register should have updated.
module sem_latch_bank_tb;

    localparam int N_SEM  = 8;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              l_sel = 1'b0, l_mem_en = 1'b0, l_wr = 1'b0;
    logic [ADDR_W-1:0] l_addr = '0;
    logic [DATA_W-1:0] l_din = '0;
    logic [DATA_W-1:0] l_dout;
    logic              r_sel = 1'b0, r_mem_en = 1'b0, r_wr = 1'b0;
    logic [ADDR_W-1:0] r_addr = '0;
    logic [DATA_W-1:0] r_din = '0;
    logic [DATA_W-1:0] r_dout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        bit                side;
        int                due;
        logic [DATA_W-1:0] val;
        string             tag;
    } item_t;

    item_t sbq[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    sem_latch_bank #(.N_SEM(N_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_addr(l_addr),
        .l_din(l_din), .l_dout(l_dout),
        .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_addr(r_addr),
        .r_din(r_din), .r_dout(r_dout)
    );

    // Compare one observed value against its expectation.
    task automatic compare(input bit side, input logic [DATA_W-1:0] exp_v, input string tag);
        logic [DATA_W-1:0] got;
        got = side ? r_dout : l_dout;
        checks++;
        if (got !== exp_v) begin
            errors++;
            $display("FAIL %s side=%s actual=%h expected=%h", tag, side ? "R" : "L", got, exp_v);
        end
    endtask

    // Monitor: pop every item whose result is due by now.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            it = sbq.pop_front();
            compare(it.side, it.val, it.tag);
        end
    end

    task automatic idle_all();
        l_sel = 0; l_mem_en = 0; l_wr = 0; l_addr = '0; l_din = '0;
        r_sel = 0; r_mem_en = 0; r_wr = 0; r_addr = '0; r_din = '0;
    endtask

    task automatic put(input bit side, input logic s, input logic m, input logic w,
                       input int a, input logic [DATA_W-1:0] d);
        if (!side) begin
            l_sel = s; l_mem_en = m; l_wr = w; l_addr = ADDR_W'(a); l_din = d;
        end else begin
            r_sel = s; r_mem_en = m; r_wr = w; r_addr = ADDR_W'(a); r_din = d;
        end
    endtask

    task automatic wrs(input bit side, input int a, input logic b);
        put(side, 1'b1, 1'b0, 1'b1, a, {{(DATA_W-1){1'b0}}, b});
    endtask

    // Legal read; expected all zeros when held, all ones otherwise.
    task automatic rds(input bit side, input int a, input bit held, input string tag);
        item_t it;
        put(side, 1'b1, 1'b0, 1'b0, a, '0);
        it.side = side;
        it.due  = cyc + 1;
        it.val  = held ? '0 : '1;
        it.tag  = tag;
        sbq.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle_all();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        idle_all();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of the outputs, then of latch 0
        compare(0, '1, "R1 reset dout");
        compare(1, '1, "R1 reset dout");
        rds(0, 0, 0, "R1 free after reset"); rds(1, 0, 0, "R1 free after reset"); tick();

        // Software-style start-up: free every latch from both sides
        for (int i = 0; i < N_SEM; i++) begin
            wrs(0, i, 1'b1); wrs(1, i, 1'b1); tick();
        end

        // R2: left takes free latch 2, writing din with upper bits set
        put(0, 1'b1, 1'b0, 1'b1, 2, 9'h1FE); tick();
        rds(0, 2, 1, "R2 owner view"); rds(1, 2, 0, "R2 other view"); tick();

        // R9: upper address bits ignored
        rds(0, 12'hA02, 1, "R9 upper addr L"); rds(1, 12'hFF2, 0, "R9 upper addr R"); tick();
        // R9: only data bit 0 sampled
        put(1, 1'b1, 1'b0, 1'b1, 5, 9'h1FE); put(0, 1'b1, 1'b0, 1'b1, 6, 9'h001); tick();
        rds(1, 5, 1, "R9 din0=0 requests"); rds(0, 6, 0, "R9 din0=1 no request"); tick();
        wrs(1, 5, 1'b1); tick();

        // R3: right requests owned latch 2
        wrs(1, 2, 1'b0); tick();
        rds(0, 2, 1, "R3 owner kept"); rds(1, 2, 0, "R3 requester waits"); tick();

        // R4: left releases, right takes over
        wrs(0, 2, 1'b1); tick();
        rds(0, 2, 0, "R4 old owner"); rds(1, 2, 1, "R4 new owner"); tick();

        // R6: left queues then cancels; right release frees the latch
        wrs(0, 2, 1'b0); tick();
        wrs(0, 2, 1'b1); tick();
        wrs(1, 2, 1'b1); tick();
        rds(0, 2, 0, "R6 cancel L"); rds(1, 2, 0, "R6 cancel R"); tick();

        // R5: take and release with nothing queued
        wrs(0, 1, 1'b0); tick();
        wrs(0, 1, 1'b1); tick();
        rds(0, 1, 0, "R5 free L"); rds(1, 1, 0, "R5 free R"); tick();

        // R7: same-cycle tie on free latch 3
        wrs(0, 3, 1'b0); wrs(1, 3, 1'b0); tick();
        rds(0, 3, 1, "R7 left wins"); rds(1, 3, 0, "R7 right loses"); tick();
        wrs(0, 3, 1'b1); tick();
        rds(0, 3, 0, "R7 queued right L"); rds(1, 3, 1, "R7 queued right R"); tick();
        wrs(1, 3, 1'b1); tick();

        // R8: read in the same cycle as a hand-over write returns the old view
        wrs(0, 4, 1'b0); tick();
        wrs(1, 4, 1'b0); tick();
        wrs(0, 4, 1'b1); rds(1, 4, 0, "R8 pre-write value"); tick();
        rds(1, 4, 1, "R8 following read"); tick();
        tick(); tick();
        compare(1, '0, "R8 hold between reads");

        // R10: illegal write ignored
        put(0, 1'b1, 1'b1, 1'b1, 6, '0); tick();
        rds(0, 6, 0, "R10 illegal write L"); rds(1, 6, 0, "R10 illegal write R"); tick();
        // R10: illegal read does not update dout
        wrs(0, 7, 1'b0); tick();
        rds(0, 0, 0, "R10 setup read"); tick();
        put(0, 1'b1, 1'b1, 1'b0, 7, '0); tick();
        tick();
        compare(0, '1, "R10 illegal read");
        // R10: illegal release ignored
        put(0, 1'b1, 1'b1, 1'b1, 7, {{(DATA_W-1){1'b0}}, 1'b1}); tick();
        rds(0, 7, 1, "R10 illegal release"); tick();

        // R11: independent latches
        wrs(1, 0, 1'b0); tick();
        rds(0, 7, 1, "R11 latch7 L"); rds(1, 0, 1, "R11 latch0 R"); tick();
        rds(0, 0, 0, "R11 latch0 L"); rds(1, 7, 0, "R11 latch7 R"); tick();
        rds(0, 4, 0, "R11 latch4 L"); rds(1, 4, 1, "R11 latch4 R"); tick();

        tick(); tick();
        summary();
        $finish;
    end

endmodule